// File: doc/BRIEF.md
# Flash command sequence decoder

This block is a synchronous model of the command interpreter that sits in front of a NOR flash array. It watches single-cycle bus writes (address, 16-bit data, write strobe) and recognises the unlock-guarded command sequences for word program, sector erase, block erase and chip erase. It also recognises the sequences that switch the read path into identification mode or query mode and back to array read. A recognised operation leaves as a one-cycle request that carries its kind, aligned target address and data. This request drives the array controller, which is outside this block.

The decoder also tracks the read mode and returns the identification words while it is in identification mode. While an operation runs, a busy flag is held high for a parameterised number of clock cycles, one count for program and one for erase. During that time every bus write is discarded. A write-protect input, active low, guards the four lowest 1K-word sectors. A synchronous abort input cancels a sequence or an operation in progress.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After rst_ni low, or after a cycle with abort_i high, read_mode_o is 0 (array), busy_o and op_valid_o are 0, and any partly entered sequence is discarded. A final program cycle written after an abort issues nothing.
- R2: The four writes AAh@5555h, 55h@2AAAh, A0h@5555h and then (A, D) produce one op_valid_o pulse, in the cycle after the fourth strobe, with op_kind_o=1, op_addr_o=A and op_data_o=D. Unlock cycles compare only addr_i[15:0] and data_i[7:0]; the other bits are ignored.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h@A issue op_kind_o=2 with op_addr_o equal to A with bits 9..0 cleared.
- R4: The same six-write sequence ending in 50h@A issues op_kind_o=3 with op_addr_o equal to A with bits 14..0 cleared, so that A[19:15] picks the 32K-word block.
- R5: The six-write sequence ending in 10h@5555h issues op_kind_o=4 with op_addr_o=0. op_keep_prot_o is 1 when wp_ni was low and 0 otherwise.
- R6: The three writes AAh@5555h, 55h@2AAAh, 90h@5555h set read_mode_o=1. In that mode id_data_o is 00BFh at rd_addr_i=0, 2761h at rd_addr_i=1, and 0 at any other address or in any other mode.
- R7: A three-write sequence ending in 98h@5555h sets read_mode_o=2. One ending in F0h@5555h sets read_mode_o=0.
- R8: A write that does not match the next expected cycle of a sequence restarts the decoder and sets read_mode_o=0, and no operation is issued.
- R9: busy_o rises in the same cycle as op_valid_o and stays high for exactly PROG_CYC cycles after a program and exactly ERASE_CYC cycles after any erase.
- R10: Writes captured while busy_o is high are ignored, the exit sequence included. A write captured in the last busy cycle is ignored, and a write captured in the cycle after busy_o falls is accepted.
- R11: With wp_ni low, a program, sector erase or block erase whose aligned target address is below 01000h issues no operation and does not set busy. With wp_ni high the same request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort to array read |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | 20 | Write word address |
| data_i | input | 16 | Write data |
| wp_ni | input | 1 | Write protect for the low 4K words, active low |
| rd_addr_i | input | 20 | Read address for identification words |
| op_valid_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 3 | 1 program, 2 sector, 3 block, 4 chip erase |
| op_addr_o | output | 20 | Aligned target address |
| op_data_o | output | 16 | Program data |
| op_keep_prot_o | output | 1 | Chip erase must preserve the protected sectors |
| busy_o | output | 1 | Operation in progress |
| read_mode_o | output | 2 | 0 array, 1 identification, 2 query |
| id_data_o | output | 16 | Identification word |

## Verification
The hardest situation to reach is the edge of the busy window. A write has to land exactly on the final busy cycle, and then on the first free cycle, to show that one is ignored and the other accepted. A mode change attempted during busy must also be shown to fail. The stimulus counts cycles from the request pulse and places the first unlock write on the last busy cycle, so a wrongly accepted write would put the decoder in identification mode. Random program and erase requests, some aimed near the 01000h protection limit with a random wp_ni, cover the remaining cases.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_SECT = 3'd2, OP_BLK = 3'd3, OP_CHIP = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0, MODE_ID = 2'd1, MODE_CFI = 2'd2
  } read_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS3, SQ_ERS4, SQ_ERS5
  } seq_state_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;
  localparam logic [7:0]  CD_AA    = 8'hAA;
  localparam logic [7:0]  CD_55    = 8'h55;
  localparam logic [7:0]  CD_PROG  = 8'hA0;
  localparam logic [7:0]  CD_ERASE = 8'h80;
  localparam logic [7:0]  CD_ID    = 8'h90;
  localparam logic [7:0]  CD_CFI   = 8'h98;
  localparam logic [7:0]  CD_EXIT  = 8'hF0;
  localparam logic [7:0]  CD_SECT  = 8'h30;
  localparam logic [7:0]  CD_BLK   = 8'h50;
  localparam logic [7:0]  CD_CHIP  = 8'h10;
endpackage

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SECT_BITS  = 10,
  parameter int PROT_SECTS = 4
) (
  input  logic              wp_ni,
  input  logic              cand_valid_i,
  input  op_kind_e          cand_kind_i,
  input  logic [ADDR_W-1:0] cand_addr_i,
  output logic              blocked_o
);
  localparam logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(PROT_SECTS << SECT_BITS);

  // aligned start below the limit means the range overlaps the guarded sectors
  always_comb begin
    blocked_o = cand_valid_i && !wp_ni && (cand_kind_i != OP_CHIP)
                && (cand_addr_i < PROT_LIMIT);
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYC  = 500,
  parameter int ERASE_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (abort_i)        cnt_q <= '0;
    else if (start_i)        cnt_q <= long_i ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R10
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R9
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !abort_i |=> busy_o);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_BITS  = 10,
  parameter int BLK_BITS   = 15,
  parameter int PROT_SECTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              blocked_i,
  output logic              cand_valid_o,
  output op_kind_e          cand_kind_o,
  output logic [ADDR_W-1:0] cand_addr_o,
  output logic              op_valid_o,
  output op_kind_e          op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_keep_prot_o,
  output read_mode_e        mode_o
);
  localparam logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(PROT_SECTS << SECT_BITS);

  seq_state_e state_q, state_d;
  read_mode_e mode_d;
  logic       bad;
  logic       hit_a, hit_b;
  logic [7:0] lo;

  assign lo    = data_i[7:0];
  assign hit_a = (addr_i[15:0] == UNLOCK_A);
  assign hit_b = (addr_i[15:0] == UNLOCK_B);

  always_comb begin
    state_d      = state_q;
    mode_d       = mode_o;
    cand_valid_o = 1'b0;
    cand_kind_o  = OP_NONE;
    cand_addr_o  = '0;
    bad          = 1'b0;
    if (wr_en_i && !busy_i) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: if (hit_a && lo == CD_AA) state_d = SQ_UNL1; else bad = 1'b1;
        SQ_UNL1: if (hit_b && lo == CD_55) state_d = SQ_UNL2; else bad = 1'b1;
        SQ_UNL2: begin
          if (!hit_a) bad = 1'b1;
          else begin
            unique case (lo)
              CD_PROG:  state_d = SQ_PROG;
              CD_ERASE: state_d = SQ_ERS3;
              CD_ID:    mode_d  = MODE_ID;
              CD_CFI:   mode_d  = MODE_CFI;
              CD_EXIT:  mode_d  = MODE_ARRAY;
              default:  bad     = 1'b1;
            endcase
          end
        end
        SQ_PROG: begin
          cand_valid_o = 1'b1;
          cand_kind_o  = OP_PROG;
          cand_addr_o  = addr_i;
        end
        SQ_ERS3: if (hit_a && lo == CD_AA) state_d = SQ_ERS4; else bad = 1'b1;
        SQ_ERS4: if (hit_b && lo == CD_55) state_d = SQ_ERS5; else bad = 1'b1;
        SQ_ERS5: begin
          if (lo == CD_SECT) begin
            cand_valid_o = 1'b1;
            cand_kind_o  = OP_SECT;
            cand_addr_o  = {addr_i[ADDR_W-1:SECT_BITS], {SECT_BITS{1'b0}}};
          end else if (lo == CD_BLK) begin
            cand_valid_o = 1'b1;
            cand_kind_o  = OP_BLK;
            cand_addr_o  = {addr_i[ADDR_W-1:BLK_BITS], {BLK_BITS{1'b0}}};
          end else if (lo == CD_CHIP && hit_a) begin
            cand_valid_o = 1'b1;
            cand_kind_o  = OP_CHIP;
          end else bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
      if (bad) mode_d = MODE_ARRAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= SQ_IDLE;
      mode_o         <= MODE_ARRAY;
      op_valid_o     <= 1'b0;
      op_kind_o      <= OP_NONE;
      op_addr_o      <= '0;
      op_data_o      <= '0;
      op_keep_prot_o <= 1'b0;
    end else if (abort_i) begin
      state_q    <= SQ_IDLE;
      mode_o     <= MODE_ARRAY;
      op_valid_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_o     <= mode_d;
      op_valid_o <= cand_valid_o && !blocked_i;
      if (cand_valid_o && !blocked_i) begin
        op_kind_o      <= cand_kind_o;
        op_addr_o      <= cand_addr_o;
        op_data_o      <= data_i;
        op_keep_prot_o <= !wp_ni;
      end
    end
  end

  // R2
  op_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> op_kind_o != OP_NONE);
  // R11
  prot_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_kind_o != OP_CHIP && !$past(wp_ni) |-> op_addr_o >= PROT_LIMIT);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          DATA_W     = 16,
  parameter int          SECT_BITS  = 10,
  parameter int          BLK_BITS   = 15,
  parameter int          PROT_SECTS = 4,
  parameter int          PROG_CYC   = 500,
  parameter int          ERASE_CYC  = 20000,
  parameter logic [15:0] MFR_ID     = 16'h00BF,
  parameter logic [15:0] DEV_ID     = 16'h2761
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_keep_prot_o,
  output logic              busy_o,
  output logic [1:0]        read_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic              cand_valid, blocked, busy;
  op_kind_e          cand_kind, op_kind;
  logic [ADDR_W-1:0] cand_addr;
  read_mode_e        mode;

  flash_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
    .BLK_BITS(BLK_BITS), .PROT_SECTS(PROT_SECTS)
  ) u_seq (
    .clk_i, .rst_ni, .abort_i, .wr_en_i, .addr_i, .data_i, .wp_ni,
    .busy_i(busy), .blocked_i(blocked),
    .cand_valid_o(cand_valid), .cand_kind_o(cand_kind), .cand_addr_o(cand_addr),
    .op_valid_o, .op_kind_o(op_kind), .op_addr_o, .op_data_o, .op_keep_prot_o,
    .mode_o(mode)
  );

  flash_prot_check #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROT_SECTS(PROT_SECTS)
  ) u_prot (
    .wp_ni, .cand_valid_i(cand_valid), .cand_kind_i(cand_kind),
    .cand_addr_i(cand_addr), .blocked_o(blocked)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i, .rst_ni, .abort_i,
    .start_i(cand_valid && !blocked),
    .long_i(cand_kind != OP_PROG),
    .busy_o(busy)
  );

  assign busy_o      = busy;
  assign op_kind_o   = op_kind;
  assign read_mode_o = mode;

  always_comb begin
    id_data_o = '0;
    if (mode == MODE_ID && rd_addr_i[ADDR_W-1:1] == '0)
      id_data_o = DATA_W'(rd_addr_i[0] ? DEV_ID : MFR_ID);
  end

  // R1
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> read_mode_o == 2'd0 && !busy_o && !op_valid_o);
  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !abort_i |=> $stable(read_mode_o));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int PC = 6;
  localparam int EC = 12;

  logic        clk = 1'b0, rst_ni = 1'b0, abort_i = 1'b0, wr_en_i = 1'b0, wp_ni = 1'b1;
  logic [19:0] addr_i = '0, rd_addr_i = '0;
  logic [15:0] data_i = '0;
  logic        op_valid_o, op_keep_prot_o, busy_o;
  logic [2:0]  op_kind_o;
  logic [19:0] op_addr_o;
  logic [15:0] op_data_o, id_data_o;
  logic [1:0]  read_mode_o;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
    .clk_i(clk), .rst_ni, .abort_i, .wr_en_i, .addr_i, .data_i, .wp_ni, .rd_addr_i,
    .op_valid_o, .op_kind_o, .op_addr_o, .op_data_o, .op_keep_prot_o,
    .busy_o, .read_mode_o, .id_data_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  // kind: 1 prog, 2 sector, 3 block, 4 chip
  task automatic do_op(input int kind, input logic [19:0] a, input logic [15:0] d);
    unlock();
    if (kind == 1) begin
      wr(20'h05555, 16'h00A0);
      wr(a, d);
    end else begin
      wr(20'h05555, 16'h0080);
      unlock();
      case (kind)
        2: wr(a, 16'h0030);
        3: wr(a, 16'h0050);
        default: wr(20'h05555, 16'h0010);
      endcase
    end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [19:0] exp_addr(input int kind, input logic [19:0] a);
    case (kind)
      1: return a;
      2: return {a[19:10], 10'b0};
      3: return {a[19:15], 15'b0};
      default: return 20'h0;
    endcase
  endfunction

  function automatic logic exp_block(input int kind, input logic [19:0] a, input logic wp);
    return !wp && kind != 4 && exp_addr(kind, a) < 20'h01000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20011));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", read_mode_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset op", op_valid_o, 0);

    // R2 program, with garbage upper bits on unlock cycles
    wr(20'hF5555, 16'h12AA); wr(20'h32AAA, 16'hFF55); wr(20'h05555, 16'h00A0);
    wr(20'h12345, 16'hBEEF);
    chk("R2 valid", op_valid_o, 1);
    chk("R2 kind", op_kind_o, 1);
    chk("R2 addr", op_addr_o, 20'h12345);
    chk("R2 data", op_data_o, 16'hBEEF);
    chk("R9 busy rise", busy_o, 1);
    busy_len(n);
    chk("R9 prog busy length", n, PC);

    do_op(2, 20'h5A7FF, 16'h0);
    chk("R3 kind", op_kind_o, 2);
    chk("R3 addr", op_addr_o, 20'h5A400);
    busy_len(n);
    chk("R9 erase busy length", n, EC);

    do_op(3, 20'hABCDE, 16'h0);
    chk("R4 kind", op_kind_o, 3);
    chk("R4 addr", op_addr_o, 20'hA8000);
    busy_len(n);

    do_op(4, 20'h0, 16'h0);
    chk("R5 kind", op_kind_o, 4);
    chk("R5 addr", op_addr_o, 0);
    chk("R5 keep wp high", op_keep_prot_o, 0);
    busy_len(n);
    wp_ni = 1'b0;
    do_op(4, 20'h0, 16'h0);
    chk("R5 valid wp low", op_valid_o, 1);
    chk("R5 keep wp low", op_keep_prot_o, 1);
    busy_len(n);
    wp_ni = 1'b1;

    // R6 identification
    unlock(); wr(20'h05555, 16'h0090);
    chk("R6 mode", read_mode_o, 1);
    rd_addr_i = 20'h0; #1 chk("R6 mfr", id_data_o, 16'h00BF);
    rd_addr_i = 20'h1; #1 chk("R6 dev", id_data_o, 16'h2761);
    rd_addr_i = 20'h2; #1 chk("R6 other addr", id_data_o, 0);
    @(negedge clk);
    unlock(); wr(20'h05555, 16'h00F0);
    rd_addr_i = 20'h0; #1 chk("R6 array no id", id_data_o, 0);
    chk("R7 exit from id", read_mode_o, 0);
    @(negedge clk);

    unlock(); wr(20'h05555, 16'h0098);
    chk("R7 cfi mode", read_mode_o, 2);
    unlock(); wr(20'h05555, 16'h00F0);
    chk("R7 cfi exit", read_mode_o, 0);

    // R8 invalid cycles
    unlock(); wr(20'h05555, 16'h0090);
    unlock(); wr(20'h05555, 16'h0077);
    chk("R8 bad third to array", read_mode_o, 0);
    chk("R8 bad third no op", op_valid_o, 0);
    unlock(); wr(20'h05555, 16'h0080); wr(20'h05555, 16'h00AA); wr(20'h01234, 16'h0055);
    wr(20'h05555, 16'h0010);
    chk("R8 bad erase no op", op_valid_o, 0);
    chk("R8 bad erase no busy", busy_o, 0);

    // R10 ignore while busy
    unlock(); wr(20'h05555, 16'h0090);
    do_op(1, 20'h40000, 16'h1111);
    unlock(); wr(20'h05555, 16'h00F0);
    chk("R10 exit ignored while busy", read_mode_o, 1);
    busy_len(n);
    unlock(); wr(20'h05555, 16'h00F0);
    chk("R10 exit after busy", read_mode_o, 0);
    do_op(1, 20'h40001, 16'h2222);
    repeat (PC - 1) @(negedge clk);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0090);
    chk("R10 last busy cycle ignored", read_mode_o, 0);
    do_op(1, 20'h40002, 16'h3333);
    busy_len(n);
    unlock(); wr(20'h05555, 16'h0090);
    chk("R10 first free cycle accepted", read_mode_o, 1);
    unlock(); wr(20'h05555, 16'h00F0);

    // R11 protection
    wp_ni = 1'b0;
    do_op(1, 20'h00FFF, 16'h5);
    chk("R11 prog blocked", op_valid_o, 0);
    chk("R11 prog no busy", busy_o, 0);
    do_op(2, 20'h00C00, 16'h0);
    chk("R11 sector blocked", op_valid_o, 0);
    do_op(3, 20'h07FFF, 16'h0);
    chk("R11 block0 blocked", op_valid_o, 0);
    do_op(1, 20'h01000, 16'h6);
    chk("R11 prog above limit", op_valid_o, 1);
    busy_len(n);
    do_op(3, 20'h08000, 16'h0);
    chk("R11 block1 allowed", op_valid_o, 1);
    busy_len(n);
    wp_ni = 1'b1;
    do_op(1, 20'h00000, 16'h7);
    chk("R11 wp high allowed", op_valid_o, 1);
    busy_len(n);

    // R1 abort
    unlock(); wr(20'h05555, 16'h00A0);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    wr(20'h00123, 16'h0034);
    chk("R1 abort discards sequence", op_valid_o, 0);
    do_op(2, 20'h30000, 16'h0);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk("R1 abort clears busy", busy_o, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int          kind = 1 + int'($urandom % 3);
      logic [19:0] a    = $urandom;
      logic [15:0] d    = $urandom;
      logic        wp   = $urandom % 2;
      logic        blk;
      if ($urandom % 2) a = a & 20'h01FFF;
      wp_ni = wp;
      blk = exp_block(kind, a, wp);
      do_op(kind, a, d);
      chk("R11 random gate", op_valid_o, !blk);
      if (!blk) begin
        chk("R2 R3 R4 random addr", op_addr_o, exp_addr(kind, a));
        if (kind == 1) chk("R2 random data", op_data_o, d);
        busy_len(n);
        chk("R9 random busy", n, kind == 1 ? PC : EC);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule